// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave

This block is the target side of a two-wire serial bus, placed in front of a byte-wide synchronous RAM. It samples the clock and data lines in the system clock domain and finds start and stop conditions. It answers a 7-bit header whose upper four bits are fixed and whose lower three bits come from strap inputs. A write transaction loads a two-byte memory pointer and then stores any number of bytes, one after another. A read transaction returns bytes from wherever the pointer currently sits, and it keeps going for as long as the master acknowledges.

Every byte goes into the array as soon as its last bit arrives. There is no page buffer and no busy time, so the slave acknowledges its header again right after any write. A protect input blocks every array write. While it is high, the header and pointer bytes are still acknowledged, but data bytes are refused and the pointer stays where it is. The data line is driven only through an active-high pull-down enable, in open-drain fashion.

The RAM has `2**ADDR_W` bytes. The default of 10 keeps elaboration small, and a build with 13 gives the full 8K array. Pointer bits above `ADDR_W` are ignored.

Top module: `twi_mem_slave`

## Requirements
- R1: A header byte whose bits 7:4 are 1010 and whose bits 3:1 equal `dev_sel_i` is acknowledged. `sda_oe_o` is 1 during the ninth clock. Bit 0 selects the direction: 0 means write, 1 means read.
- R2: When the header does not match, `sda_oe_o` stays 0 for every following bit until the next start.
- R3: In a write transaction the header is followed by the pointer high byte and then the pointer low byte. Both bytes are acknowledged, even with `wp_i` high. Only the low `ADDR_W` bits of the 16-bit value are kept.
- R4: With `wp_i` low, each write data byte is stored at the pointer once its 8th bit is received. The byte is acknowledged and the pointer then advances by one. The header is acknowledged again right after a stop.
- R5: A start or stop that arrives before the 8th bit of a data byte leaves both the array and the pointer unchanged.
- R6: A read begins at the current pointer. That is either the value just loaded or the location after the last byte accessed. A random read is a write header plus the pointer, then a repeated start and a read header.
- R7: A read sends 8 bits MSB first, with `sda_oe_o` set to the inverse of each bit. A master ACK (data line low on the ninth clock) continues with the next byte. A NACK ends the read, and `sda_oe_o` stays 0.
- R8: The pointer wraps from `2**ADDR_W-1` to 0, both in write bursts and in read bursts.
- R9: With `wp_i` high, write data bytes are not acknowledged. The array is not written and the pointer does not advance.
- R10: `sda_oe_o` changes only while the clock line is low.
- R11: A start always returns the slave to waiting for a header, and a stop returns it to idle. Neither one leaves the data line driven.
- R12: After reset, `sda_oe_o` is 0 and the pointer is 0. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| dev_sel_i | input | 3 | Strap value matched against header bits 3:1 |
| wp_i | input | 1 | Write protect; high blocks all array writes. Tie low when unused |
| sda_oe_o | output | 1 | Pull-down enable for the data line; 1 drives it low |

## Verification
On the 8th rising clock edge of a write data byte, three things happen in the same cycle: the array commit, the pointer increment and the protect decision. The bench provokes this by raising `wp_i` in the middle of a stream of write transactions. It then judges the result through the missing acknowledges and through later reads, which must show both the old contents and the unmoved pointer. A second collision is a start or stop arriving part-way through a byte. The bench cuts a data byte after four and after five bits and then reads back from the current pointer.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } twi_phase_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // header bits 7:1 against the fixed type code and the strap value
  function automatic logic hdr_match(input logic [7:0] hdr, input logic [2:0] sel);
    return hdr[7:1] == {DEV_TYPE, sel};
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int TAPS = SYNC_STAGES + 1;

  logic [TAPS-1:0] scl_q;
  logic [TAPS-1:0] sda_q;
  logic            scl_d;
  logic            sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[TAPS-2:0], scl_i};
      sda_q <= {sda_q[TAPS-2:0], sda_i};
    end
  end

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];
  assign scl_d = scl_q[SYNC_STAGES];
  assign sda_d = sda_q[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        dev_sel,
  input  logic              wp,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] ptr,
  output logic              sda_oe,
  output twi_phase_e        phase
);

  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] BYTE_END = 4'd8;

  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_load(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] full;
    full = {hi, lo};
    return full[ADDR_W-1:0];
  endfunction

  logic [3:0] bit_cnt;
  logic       in_ack;
  logic       ack_go;
  logic       rw_q;
  logic [7:0] shreg;
  logic [7:0] ahi_q;
  logic [7:0] byte_in;
  logic       rx_phase;
  logic       rx_last;

  assign byte_in   = {shreg[6:0], sda_s};
  assign rx_phase  = (phase == PH_DEV) || (phase == PH_AHI) ||
                     (phase == PH_ALO) || (phase == PH_WR);
  assign rx_last   = rx_phase & scl_rise & ~in_ack & (bit_cnt == LAST_BIT);
  assign mem_we    = rx_last & (phase == PH_WR) & ~wp;
  assign mem_wdata = byte_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      ack_go  <= 1'b0;
      rw_q    <= 1'b0;
      shreg   <= '0;
      ahi_q   <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      phase   <= PH_DEV;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      ack_go  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      ack_go  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (phase == PH_RD) begin
      if (scl_rise && !in_ack && bit_cnt < BYTE_END) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) ptr <= ptr_next(ptr);
      end else if (scl_fall && !in_ack && bit_cnt != '0) begin
        if (bit_cnt == BYTE_END) begin
          sda_oe <= 1'b0;
          in_ack <= 1'b1;
        end else begin
          shreg  <= {shreg[6:0], 1'b0};
          sda_oe <= ~shreg[6];
        end
      end else if (scl_rise && in_ack) begin
        if (sda_s) phase <= PH_IDLE;
      end else if (scl_fall && in_ack) begin
        in_ack  <= 1'b0;
        bit_cnt <= '0;
        shreg   <= rd_data;
        sda_oe  <= ~rd_data[7];
      end
    end else if (rx_phase) begin
      if (scl_rise && !in_ack && bit_cnt < BYTE_END) begin
        shreg   <= byte_in;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          case (phase)
            PH_DEV: begin
              if (hdr_match(byte_in, dev_sel)) begin
                ack_go <= 1'b1;
                rw_q   <= byte_in[0];
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_AHI: begin
              ahi_q  <= byte_in;
              ack_go <= 1'b1;
            end
            PH_ALO: begin
              ptr    <= ptr_load(ahi_q, byte_in);
              ack_go <= 1'b1;
            end
            default: begin
              if (!wp) ptr <= ptr_next(ptr);
              ack_go <= ~wp;
            end
          endcase
        end
      end else if (scl_fall && !in_ack && bit_cnt == BYTE_END) begin
        in_ack <= 1'b1;
        sda_oe <= ack_go;
      end else if (scl_fall && in_ack) begin
        in_ack  <= 1'b0;
        bit_cnt <= '0;
        ack_go  <= 1'b0;
        sda_oe  <= 1'b0;
        case (phase)
          PH_DEV: begin
            if (rw_q) begin
              phase  <= PH_RD;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              phase <= PH_AHI;
            end
          end
          PH_AHI:  phase <= PH_ALO;
          default: phase <= PH_WR;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              mem_we;
  logic [7:0]        mem_wdata;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] ptr;
  twi_phase_e        phase;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  twi_slave_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .dev_sel   (dev_sel_i),
    .wp        (wp_i),
    .rd_data   (rd_data),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ptr       (ptr),
    .sda_oe    (sda_oe_o),
    .phase     (phase)
  );

  twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) array_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ptr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe_o,
  input logic              wp_i,
  input logic              mem_we,
  input logic              start_evt,
  input logic              stop_evt,
  input logic [ADDR_W-1:0] ptr,
  input twi_phase_e        phase
);

  // R10
  oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  // R9
  wp_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !mem_we);

  // R4
  commit_steps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  // R11
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (phase == PH_IDLE) && !sda_oe_o);

  // R11
  start_stop_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt}));

  // R2
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe_o);

  // R5
  start_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !mem_we);

endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe_o  (sda_oe_o),
  .wp_i      (wp_i),
  .mem_we    (mem_we),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .ptr       (ptr),
  .phase     (phase)
);

// File: tb/twi_mem_slave_tb.sv
module twi_mem_slave_tb_top;

  localparam int HP = 16;
  localparam int QW = 4;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] HDR_W = 8'hAA;
  localparam logic [7:0] HDR_R = 8'hAB;
  localparam int NVEC = 6;
  // {write pointer, read pointer, data}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 8'hA5},
    {16'h0001, 16'h0001, 8'h3C},
    {16'h03FF, 16'h03FF, 8'h7E},
    {16'hFC10, 16'h0010, 8'h81},
    {16'h0155, 16'h0155, 8'h00},
    {16'h02AA, 16'h02AA, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic oe_prev = 1'b0;
  int   n_chk = 0;
  int   n_err = 0;
  int   r10_bad = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  twi_mem_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .dev_sel_i (SEL),
    .wp_i      (wp),
    .sda_oe_o  (sda_oe)
  );

  // R10 monitor: the enable must never move while the bus clock is high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) r10_bad++;
    oe_prev <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(QW);
    scl_m = 1'b1; wt(HP);
    sda_m = 1'b0; wt(HP);
    scl_m = 1'b0; wt(QW);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HP);
    scl_m = 1'b1; wt(HP);
    sda_m = 1'b1; wt(HP);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; wt(HP);
    scl_m = 1'b1; wt(HP / 2);
    r = sda_line; wt(HP / 2);
    scl_m = 1'b0; wt(QW);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
    bus_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, r);
      v = {v[6:0], r};
    end
    bus_bit(~mack, r);
  endtask

  task automatic ptr_phase(input logic [15:0] a);
    logic ak;
    bus_start();
    send_byte(HDR_W, ak); check("R1 write header ack", ak, 1);
    send_byte(a[15:8], ak); check("R3 pointer high ack", ak, 1);
    send_byte(a[7:0], ak);  check("R3 pointer low ack", ak, 1);
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
    logic ak;
    ptr_phase(a);
    send_byte(d, ak); check("R4 data ack", ak, 1);
    bus_stop();
  endtask

  task automatic rand_read(input logic [15:0] a, output logic [7:0] d);
    logic ak;
    ptr_phase(a);
    bus_start();
    send_byte(HDR_R, ak); check("R6 read header ack", ak, 1);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic ak;
    bus_start();
    send_byte(HDR_R, ak); check("R1 read header ack", ak, 1);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ak;
    logic r;

    wt(5);
    check("R12 enable low in reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(10);
    check("R12 enable low after reset", sda_oe, 0);

    // table walk: single writes, then random read-back (R3 upper pointer bits ignored)
    for (int v = 0; v < NVEC; v++) begin
      mem_write(VEC[v][39:24], VEC[v][7:0]);
      rand_read(VEC[v][23:8], d);
      check("R6 R3 table read-back", d, VEC[v][7:0]);
    end

    // R12: reset sends the pointer back to 0, array kept
    wt(2); rst_n = 1'b0; wt(4);
    check("R12 enable low during mid-run reset", sda_oe, 0);
    rst_n = 1'b1; wt(10);
    cur_read(d);
    check("R12 pointer zero after reset", d, 8'hA5);

    // R8 write burst wrapping past the top
    ptr_phase(16'h03FE);
    send_byte(8'h11, ak); check("R4 burst byte 0 ack", ak, 1);
    send_byte(8'h22, ak); check("R4 burst byte 1 ack", ak, 1);
    send_byte(8'h33, ak); check("R8 burst wrap byte ack", ak, 1);
    bus_stop();
    cur_read(d);
    check("R6 R8 current read after wrapped burst", d, 8'h3C);

    // R7 R8 read burst across the wrap
    ptr_phase(16'h03FE);
    bus_start();
    send_byte(HDR_R, ak); check("R1 read header after restart", ak, 1);
    recv_byte(d, 1'b1); check("R7 burst read byte 0", d, 8'h11);
    recv_byte(d, 1'b1); check("R7 burst read byte 1", d, 8'h22);
    recv_byte(d, 1'b0); check("R8 burst read wrapped byte", d, 8'h33);
    check("R7 released after NACK", sda_oe, 0);
    bus_stop();

    // R2 header mismatch stays silent
    bus_start();
    send_byte(8'hA0, ak); check("R2 wrong header not acked", ak, 0);
    send_byte(8'h55, ak); check("R2 following byte not acked", ak, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA1, ak); check("R2 wrong read header not acked", ak, 0);
    recv_byte(d, 1'b0);   check("R2 line left released", d, 8'hFF);
    bus_stop();

    // R9 write protect
    mem_write(16'h0020, 8'hC3);
    mem_write(16'h0021, 8'hD4);
    wp = 1'b1;
    ptr_phase(16'h0020);
    send_byte(8'h5A, ak); check("R9 protected byte refused", ak, 0);
    send_byte(8'h6B, ak); check("R9 second protected byte refused", ak, 0);
    bus_stop();
    wp = 1'b0;
    cur_read(d);
    check("R9 pointer frozen and array kept", d, 8'hC3);
    rand_read(16'h0021, d);
    check("R9 next location kept", d, 8'hD4);

    // R5 R11 abort by repeated start after four bits
    mem_write(16'h0030, 8'hE7);
    ptr_phase(16'h0030);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, r);
    bus_start();
    send_byte(HDR_R, ak); check("R11 header after mid-byte start", ak, 1);
    recv_byte(d, 1'b0);   check("R5 start abort keeps array", d, 8'hE7);
    bus_stop();

    // R5 R11 abort by stop after five bits
    ptr_phase(16'h0030);
    for (int i = 0; i < 5; i++) bus_bit(1'b0, r);
    bus_stop();
    check("R11 released after stop", sda_oe, 0);
    cur_read(d);
    check("R5 stop abort keeps array and pointer", d, 8'hE7);

    check("R10 enable moved only with clock low", r10_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule